// File: doc/BRIEF.md
# Calendar Counter with Deferred Register Commit

This block keeps the current wall-clock time (second, minute, hour) and calendar date (day, month, year offset, leap flag). The counter advances once for each pulse on a one-second tick input. The tick is a single-cycle pulse that is already synchronous to the register clock. Software reads and writes the time and date through a small register port. A read returns the live value, so two reads taken on either side of a tick can differ.

Writes to the time or date register are not applied at once. An accepted write goes into a holding slot and raises that register's busy flag in the control word. The held value replaces the live value on the next tick, and the busy flag clears on that same tick. A tick that commits held data does not also advance the calendar. While a busy flag is set, further writes to that register are dropped. Software should therefore poll the flag before it writes again.

The year is a 6-bit offset from 1970 and covers 1970 to 2033. The leap flag sets the length of February. Software can write the leap flag, and the block recomputes it whenever the year carries.

Top module: `cal_rtc_top`

## Requirements
- R1: After a synchronous active-low reset, the time register reads 0. The date register reads day 1, month 1, year 0, leap 0, which is 0x00000101. The control register reads 0.
- R2: Register map. The control word is at 0x00, the date register at 0x10 and the time register at 0x14. The date register holds day in bits 4:0, month in bits 11:8, year offset in bits 21:16 and leap in bit 22. The time register holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Every other bit reads 0, and any other address reads 0.
- R3: A write to the time register when control bit 8 is clear stores the value and sets bit 8. Bit 8 stays set, and the time register keeps its old value, until the next tick.
- R4: A write to the date register when control bit 7 is clear stores the value and sets bit 7. Bit 7 stays set until the next tick.
- R5: On a tick, every register with a held value takes that value and its busy bit clears. If any value was held, that tick advances neither the time nor the date.
- R6: A write to a register whose busy bit is set is ignored. The value committed on the next tick is the one written first.
- R7: On a tick with nothing held, seconds advance. 59 wraps to 0 and carries into minutes, minutes wrap 59 to 0 into hours, and hours wrap 23 to 0 into the day.
- R8: The day wraps to 1 after the last day of the month. That is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. For month 2 it is 29 with leap set and 28 with leap clear.
- R9: Month 12 wraps to 1 and increments the year offset, which wraps from 63 to 0. On that carry the leap flag is set exactly when the new offset mod 4 equals 2.
- R10: A write and a tick in the same cycle, with nothing held, both take effect. The tick advances the counter and the write is held. The written value lands on the following tick.
- R11: Without a tick, the time and date registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second, synchronous to clk |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
A software write and a one-second tick can arrive in the same clock cycle. The outcome then depends on whether a value is already held for that register. If nothing is held, the tick advances the calendar and the write is kept for the next tick. If a value is held, the tick commits it and the write in that same cycle is dropped, because the busy flag was still set when it arrived. The bench drives both cases in a single cycle, with the write strobe and the tick raised together. A behavioural model, with the commit and drop rules written separately, is compared against the read port on every cycle, and named checks are taken on the cycle after the collision.

// File: rtl/cal_rtc_pkg.sv
// Package: field widths, bit positions, packed calendar types and the
// helper functions shared by the calendar counter and its checker.
package cal_rtc_pkg;

    parameter int REG_W  = 32;
    parameter int SEC_W  = 6;
    parameter int MIN_W  = 6;
    parameter int HR_W   = 5;
    parameter int DAY_W  = 5;
    parameter int MON_W  = 4;
    parameter int YR_W   = 6;

    // Field positions inside the software-visible words
    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HR_LSB   = 16;
    localparam int DAY_LSB  = 0;
    localparam int MON_LSB  = 8;
    localparam int YR_LSB   = 16;
    localparam int LEAP_BIT = 22;
    localparam int TBUSY_BIT = 8;
    localparam int DBUSY_BIT = 7;

    // Rollover limits
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(59);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(59);
    localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(23);
    localparam logic [MON_W-1:0] MON_LAST = MON_W'(12);

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic             leap;
        logic [YR_W-1:0]  yr;
        logic [MON_W-1:0] mon;
        logic [DAY_W-1:0] day;
    } cal_date_t;

    localparam int TIME_BITS = $bits(cal_time_t);
    localparam int DATE_BITS = $bits(cal_date_t);

    // Last day of a month given the leap flag
    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                   input logic leap);
        logic [DAY_W-1:0] n;
        case (m)
            MON_W'(2):                         n = leap ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4), MON_W'(6),
            MON_W'(9), MON_W'(11):             n = DAY_W'(30);
            default:                           n = DAY_W'(31);
        endcase
        return n;
    endfunction

    // Leap rule for an offset from 1970 within 1970..2033: offset mod 4 == 2
    function automatic logic year_is_leap(input logic [YR_W-1:0] y);
        return (y[1:0] == 2'b10);
    endfunction

    function automatic logic [REG_W-1:0] pack_time(input cal_time_t t);
        logic [REG_W-1:0] r;
        r = '0;
        r[SEC_LSB +: SEC_W] = t.sec;
        r[MIN_LSB +: MIN_W] = t.min;
        r[HR_LSB  +: HR_W]  = t.hr;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_date(input cal_date_t d);
        logic [REG_W-1:0] r;
        r = '0;
        r[DAY_LSB +: DAY_W] = d.day;
        r[MON_LSB +: MON_W] = d.mon;
        r[YR_LSB  +: YR_W]  = d.yr;
        r[LEAP_BIT]         = d.leap;
        return r;
    endfunction

    function automatic cal_time_t unpack_time(input logic [REG_W-1:0] w);
        cal_time_t t;
        t.sec = w[SEC_LSB +: SEC_W];
        t.min = w[MIN_LSB +: MIN_W];
        t.hr  = w[HR_LSB  +: HR_W];
        return t;
    endfunction

    function automatic cal_date_t unpack_date(input logic [REG_W-1:0] w);
        cal_date_t d;
        d.day  = w[DAY_LSB +: DAY_W];
        d.mon  = w[MON_LSB +: MON_W];
        d.yr   = w[YR_LSB  +: YR_W];
        d.leap = w[LEAP_BIT];
        return d;
    endfunction

endpackage

// File: rtl/cal_wrap_step.sv
// One wrapping counter digit.
// Does:    when en is high, steps cur by one, or returns LOW once cur has
//          reached limit; wrap reports that a carry leaves this digit.
// Assumes: purely combinational; the owner holds the register.
module cal_wrap_step #(
    parameter int             W   = 6,
    parameter logic [W-1:0]   LOW = '0
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] limit,
    input  logic         en,
    output logic [W-1:0] nxt,
    output logic         wrap
);

    logic at_limit;

    // Compare against the limit; >= so an out-of-range value also wraps
    assign at_limit = (cur >= limit);

    // Carry leaves this digit only when enabled and at the limit
    assign wrap = en & at_limit;

    // Next value of the digit
    always_comb begin
        if (!en)
            nxt = cur;
        else if (at_limit)
            nxt = LOW;
        else
            nxt = cur + W'(1);
    end

endmodule

// File: rtl/cal_commit_slot.sv
// Holding slot for one deferred software write.
// Does:    captures a write when not busy, raises busy, and drops busy on
//          the next tick, when the owner copies the held value.
// Assumes: tick is one clk cycle wide; a write in a busy cycle is dropped,
//          even if a tick in the same cycle clears busy.
module cal_commit_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_hit,
    input  logic [W-1:0] wval,
    output logic         busy,
    output logic [W-1:0] held
);

    // Busy flag and held value; a write taken in a tick cycle stays pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            held <= '0;
        end else begin
            if (tick)
                busy <= 1'b0;
            if (wr_hit && !busy) begin
                held <= wval;
                busy <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cal_time_ctr.sv
// Second/minute/hour counter.
// Does:    steps on adv with the 59/59/23 wraps, loads a full value on
//          load, and reports a carry into the day.
// Assumes: load and adv are never high together (the top decides).
module cal_time_ctr
    import cal_rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  cal_time_t load_val,
    output cal_time_t cur,
    output logic      day_carry
);

    cal_time_t nxt;
    logic      sec_wrap;
    logic      min_wrap;
    logic      hr_wrap;

    cal_wrap_step #(.W(SEC_W), .LOW('0)) u_sec (
        .cur(cur.sec), .limit(SEC_LAST), .en(adv),
        .nxt(nxt.sec), .wrap(sec_wrap)
    );

    cal_wrap_step #(.W(MIN_W), .LOW('0)) u_min (
        .cur(cur.min), .limit(MIN_LAST), .en(sec_wrap),
        .nxt(nxt.min), .wrap(min_wrap)
    );

    cal_wrap_step #(.W(HR_W), .LOW('0)) u_hr (
        .cur(cur.hr), .limit(HR_LAST), .en(min_wrap),
        .nxt(nxt.hr), .wrap(hr_wrap)
    );

    // Midnight carry to the date counter
    assign day_carry = hr_wrap;

    // Time register: reset to midnight, commit has priority over stepping
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (load)
            cur <= load_val;
        else if (adv)
            cur <= nxt;
    end

endmodule

// File: rtl/cal_date_ctr.sv
// Day/month/year counter with the leap flag.
// Does:    steps the day on adv, using the month length that the month and
//          leap flag select; wraps the month into the year and recomputes
//          leap on each year carry.
// Assumes: the year is an offset from 1970 that wraps 63 -> 0.
module cal_date_ctr
    import cal_rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  cal_date_t load_val,
    output cal_date_t cur
);

    localparam cal_date_t DATE_RST = '{leap: 1'b0, yr: '0,
                                       mon: MON_W'(1), day: DAY_W'(1)};

    cal_date_t        nxt;
    logic [DAY_W-1:0] last_day;
    logic             day_wrap;
    logic             mon_wrap;
    logic [YR_W-1:0]  yr_inc;

    // Month length for the current month and leap flag
    assign last_day = month_len(cur.mon, cur.leap);

    cal_wrap_step #(.W(DAY_W), .LOW(DAY_W'(1))) u_day (
        .cur(cur.day), .limit(last_day), .en(adv),
        .nxt(nxt.day), .wrap(day_wrap)
    );

    cal_wrap_step #(.W(MON_W), .LOW(MON_W'(1))) u_mon (
        .cur(cur.mon), .limit(MON_LAST), .en(day_wrap),
        .nxt(nxt.mon), .wrap(mon_wrap)
    );

    // Year step and leap recomputation on a month carry
    always_comb begin
        yr_inc = cur.yr + YR_W'(1);
        if (mon_wrap) begin
            nxt.yr   = yr_inc;
            nxt.leap = year_is_leap(yr_inc);
        end else begin
            nxt.yr   = cur.yr;
            nxt.leap = cur.leap;
        end
    end

    // Date register: reset to 1 January of offset 0, commit before step
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= DATE_RST;
        else if (load)
            cur <= load_val;
        else if (adv)
            cur <= nxt;
    end

endmodule

// File: rtl/cal_rtc_top.sv
// Calendar counter with deferred time/date writes.
// Does:    decodes the register port, parks time and date writes in
//          holding slots, and commits them on the next second tick in place
//          of advancing; otherwise advances the calendar on each tick.
// Assumes: sec_tick is a single-cycle pulse synchronous to clk; reads are
//          combinational from reg_addr.
module cal_rtc_top
    import cal_rtc_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS  = 'h00,
    parameter logic [ADDR_W-1:0] DATE_OFS  = 'h10,
    parameter logic [ADDR_W-1:0] TIME_OFS  = 'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);

    logic                 wr_time_hit;
    logic                 wr_date_hit;
    logic                 time_busy;
    logic                 date_busy;
    logic [TIME_BITS-1:0] time_held_raw;
    logic [DATE_BITS-1:0] date_held_raw;
    cal_time_t            time_held;
    cal_date_t            date_held;
    cal_time_t            time_cur;
    cal_date_t            date_cur;
    logic                 any_held;
    logic                 step_en;
    logic                 day_carry;
    logic [REG_W-1:0]     ctrl_word;

    // Address decode of the write strobe
    assign wr_time_hit = reg_we && (reg_addr == TIME_OFS);
    assign wr_date_hit = reg_we && (reg_addr == DATE_OFS);

    cal_commit_slot #(.W(TIME_BITS)) u_time_slot (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick),
        .wr_hit(wr_time_hit), .wval(unpack_time(reg_wdata)),
        .busy(time_busy), .held(time_held_raw)
    );

    cal_commit_slot #(.W(DATE_BITS)) u_date_slot (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick),
        .wr_hit(wr_date_hit), .wval(unpack_date(reg_wdata)),
        .busy(date_busy), .held(date_held_raw)
    );

    assign time_held = cal_time_t'(time_held_raw);
    assign date_held = cal_date_t'(date_held_raw);

    // A tick that commits anything does not also advance
    assign any_held = time_busy | date_busy;
    assign step_en  = sec_tick & ~any_held;

    cal_time_ctr u_time (
        .clk(clk), .rst_n(rst_n),
        .adv(step_en), .load(sec_tick & time_busy), .load_val(time_held),
        .cur(time_cur), .day_carry(day_carry)
    );

    cal_date_ctr u_date (
        .clk(clk), .rst_n(rst_n),
        .adv(day_carry), .load(sec_tick & date_busy), .load_val(date_held),
        .cur(date_cur)
    );

    // Control word: per-register busy flags, all other bits zero
    always_comb begin
        ctrl_word            = '0;
        ctrl_word[TBUSY_BIT] = time_busy;
        ctrl_word[DBUSY_BIT] = date_busy;
    end

    // Read multiplexer
    always_comb begin
        if (reg_addr == CTRL_OFS)
            reg_rdata = ctrl_word;
        else if (reg_addr == DATE_OFS)
            reg_rdata = pack_date(date_cur);
        else if (reg_addr == TIME_OFS)
            reg_rdata = pack_time(time_cur);
        else
            reg_rdata = '0;
    end

endmodule

// File: rtl/cal_rtc_chk.sv
// Checker for cal_rtc_top: busy flags, commit and hold rules.
// Assumes: attached by the bind at the end of this file.
module cal_rtc_chk
    import cal_rtc_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sec_tick,
    input logic      wr_time_hit,
    input logic      wr_date_hit,
    input logic      busy_t,
    input logic      busy_d,
    input cal_time_t time_q,
    input cal_date_t date_q,
    input cal_time_t time_pend,
    input cal_date_t date_pend
);

    // R3
    time_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_t && !sec_tick |=> busy_t);

    // R4
    date_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_date_hit && !sec_tick |=> busy_d);

    // R5
    time_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick && busy_t |=> time_q == $past(time_pend));

    // R5
    date_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick && busy_d |=> date_q == $past(date_pend));

    // R5
    commit_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick && busy_t && !busy_d |=> $stable(date_q));

    // R5
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick && !wr_time_hit |=> !busy_t);

    // R6
    busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_time_hit && busy_t |=> $stable(time_pend));

    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(time_q) && $stable(date_q));

endmodule

bind cal_rtc_top cal_rtc_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .wr_time_hit(wr_time_hit), .wr_date_hit(wr_date_hit),
    .busy_t(time_busy), .busy_d(date_busy),
    .time_q(time_cur), .date_q(date_cur),
    .time_pend(time_held), .date_pend(date_held)
);

// File: tb/cal_rtc_top_tb_top.sv
`timescale 1ns/1ps
module cal_rtc_top_tb_top;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_DATE = 8'h10;
    localparam logic [7:0] A_TIME = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    always #2.5 clk = ~clk;

    cal_rtc_top dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Behavioural reference model
    int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_leap;
    bit m_bt, m_bd;
    logic [31:0] m_pt, m_pd;

    function automatic int dim(int mon, int leap);
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic m_reset();
        m_sec = 0; m_min = 0; m_hr = 0;
        m_day = 1; m_mon = 1; m_yr = 0; m_leap = 0;
        m_bt = 0; m_bd = 0; m_pt = '0; m_pd = '0;
    endtask

    task automatic m_advance();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0; m_day++;
                    if (m_day > dim(m_mon, m_leap)) begin
                        m_day = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1;
                            m_yr = (m_yr + 1) % 64;
                            m_leap = ((m_yr + 1970) % 4 == 0) ? 1 : 0;
                        end
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        bit obt, obd;
        if (!rst_n) begin
            m_reset();
        end else begin
            obt = m_bt; obd = m_bd;
            if (sec_tick) begin
                if (obt || obd) begin
                    if (obt) begin
                        m_sec = m_pt & 32'h3f;
                        m_min = (m_pt >> 8) & 32'h3f;
                        m_hr  = (m_pt >> 16) & 32'h1f;
                    end
                    if (obd) begin
                        m_day  = m_pd & 32'h1f;
                        m_mon  = (m_pd >> 8) & 32'hf;
                        m_yr   = (m_pd >> 16) & 32'h3f;
                        m_leap = (m_pd >> 22) & 32'h1;
                    end
                    m_bt = 0; m_bd = 0;
                end else begin
                    m_advance();
                end
            end
            if (reg_we && reg_addr == A_TIME && !obt) begin m_pt = reg_wdata; m_bt = 1; end
            if (reg_we && reg_addr == A_DATE && !obd) begin m_pd = reg_wdata; m_bd = 1; end
        end
    end

    function automatic logic [31:0] exp_read(logic [7:0] a);
        if (a == A_CTRL) return (32'(m_bt) << 8) | (32'(m_bd) << 7);
        if (a == A_DATE) return 32'(m_day) | (32'(m_mon) << 8) | (32'(m_yr) << 16) | (32'(m_leap) << 22);
        if (a == A_TIME) return 32'(m_sec) | (32'(m_min) << 8) | (32'(m_hr) << 16);
        return 32'h0;
    endfunction

    // Every-cycle comparison against the model (register layout, R2)
    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (reg_rdata !== exp_read(reg_addr)) begin
                errors++;
                $display("FAIL R2 cycle compare addr=%h actual=%h expected=%h",
                         reg_addr, reg_rdata, exp_read(reg_addr));
            end
        end
    end

    task automatic cyc(bit we, logic [7:0] a, logic [31:0] d, bit tk);
        @(negedge clk); #0.5;
        reg_we = we; reg_addr = a; reg_wdata = d; sec_tick = tk;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic tick1();
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
        cyc(1'b0, a, 32'h0, 1'b0);
        #0.5;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 32'h0, 1'b0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #0.5;
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1 reset state, R2 unmapped address
        rd_chk(A_CTRL, 32'h0, "R1 ctrl");
        rd_chk(A_DATE, 32'h00000101, "R1 date");
        rd_chk(A_TIME, 32'h0, "R1 time");
        rd_chk(8'h04, 32'h0, "R2 unmapped");

        // R7 plain stepping, R11 hold without tick
        tick1(); tick1(); tick1();
        rd_chk(A_TIME, 32'h3, "R7 three ticks");
        idle(10);
        rd_chk(A_TIME, 32'h3, "R11 no tick");

        // R3 deferred time write, R6 drop while busy, R5 commit
        wr(A_TIME, 32'h00173B3A);
        rd_chk(A_CTRL, 32'h100, "R3 busy bit");
        rd_chk(A_TIME, 32'h3, "R3 old value kept");
        wr(A_TIME, 32'h00010203);
        tick1();
        rd_chk(A_TIME, 32'h00173B3A, "R6 first write wins");
        rd_chk(A_CTRL, 32'h0, "R5 busy cleared");
        rd_chk(A_DATE, 32'h00000101, "R5 no date step");

        // R4 date write, leap February
        wr(A_DATE, 32'h005E021C);
        rd_chk(A_CTRL, 32'h80, "R4 busy bit");
        tick1();
        rd_chk(A_DATE, 32'h005E021C, "R5 date commit");
        rd_chk(A_TIME, 32'h00173B3A, "R5 no time step");
        tick1(); tick1();
        rd_chk(A_TIME, 32'h0, "R7 midnight wrap");
        rd_chk(A_DATE, 32'h005E021D, "R8 leap Feb 29");

        // R8 non-leap February
        wr(A_DATE, 32'h001F021C); wr(A_TIME, 32'h00173B3B);
        rd_chk(A_CTRL, 32'h180, "R3 R4 both busy");
        tick1();
        rd_chk(A_CTRL, 32'h0, "R5 both cleared");
        tick1();
        rd_chk(A_DATE, 32'h001F0301, "R8 Feb 28 to Mar 1");

        // R8 thirty-day and thirty-one-day months
        wr(A_DATE, 32'h001F041E); wr(A_TIME, 32'h00173B3B); tick1(); tick1();
        rd_chk(A_DATE, 32'h001F0501, "R8 Apr 30 to May 1");
        wr(A_DATE, 32'h0000011F); wr(A_TIME, 32'h00173B3B); tick1(); tick1();
        rd_chk(A_DATE, 32'h00000201, "R8 Jan 31 to Feb 1");

        // R9 year carry and leap recompute, year wrap
        wr(A_DATE, 32'h00010C1F); wr(A_TIME, 32'h00173B3B); tick1(); tick1();
        rd_chk(A_DATE, 32'h00420101, "R9 year carry sets leap");
        wr(A_DATE, 32'h003F0C1F); wr(A_TIME, 32'h00173B3B); tick1(); tick1();
        rd_chk(A_DATE, 32'h00000101, "R9 year 63 wraps to 0");
        rd_chk(A_TIME, 32'h0, "R7 time wrap at year end");

        // R10 write and tick in one cycle with nothing held
        cyc(1'b1, A_TIME, 32'h000A0B0C, 1'b1);
        rd_chk(A_TIME, 32'h1, "R10 tick still steps");
        rd_chk(A_CTRL, 32'h100, "R10 write held");
        tick1();
        rd_chk(A_TIME, 32'h000A0B0C, "R10 value lands next tick");

        // R6 write in the same cycle as a committing tick is dropped
        wr(A_TIME, 32'h00000A3B);
        cyc(1'b1, A_TIME, 32'h00050505, 1'b1);
        rd_chk(A_CTRL, 32'h0, "R6 colliding write dropped");
        rd_chk(A_TIME, 32'h00000A3B, "R5 collision commit");
        tick1();
        rd_chk(A_TIME, 32'h00000B00, "R7 minute carry");
        wr(A_TIME, 32'h00003B3B); tick1(); tick1();
        rd_chk(A_TIME, 32'h00010000, "R7 hour carry");

        // R6 date write while busy
        wr(A_DATE, 32'h00000505); wr(A_DATE, 32'h00000909); tick1();
        rd_chk(A_DATE, 32'h00000505, "R6 date busy drop");

        idle(3);
        summary();
        $finish;
    end

endmodule